// File: doc/BRIEF.md
# Streaming SPI Flash Byte Reader

This block pulls a continuous stream of bytes out of a serial NOR flash over a single-bit SPI link. A rising read-enable opens a transaction. The block pulls chip select low and shifts out the read opcode 0x03, followed by a 24-bit start address. It then keeps the serial clock running and collects one data byte after another from consecutive flash addresses. Each finished byte goes to the client with a strobe that lasts one clock. The stream runs as long as read-enable stays high. There is no byte count and no per-request length, so a client such as a sample player can drain the flash at a steady rate.

The serial clock runs at half the system clock and idles low (SPI mode 0). The bus carries one bit every two system clocks, so one data byte takes 16 clocks. The controller has three states:

- **IDLE**: chip select is high and SCLK is low.
- **HEADER**: shifts out 32 command and address bits.
- **STREAM**: shifts in data.

The transitions are:

- IDLE→HEADER when read-enable is seen high.
- HEADER→STREAM on the falling SCLK edge that ends the last address bit.
- HEADER→IDLE and STREAM→IDLE whenever read-enable is low. This aborts the transaction, and any partial byte is dropped.

Top module: `flash_stream_reader`

## Requirements
- R1: During and after a synchronous active-low reset, chip select is high, SCLK is low, the valid strobe is low and the data output is zero.
- R2: Read-enable seen high in IDLE pulls chip select low on the next clock. The block then sends 32 header bits, MSB first: opcode 0x03 in the top eight bits, then the 24-bit start address, most significant byte first.
- R3: While a transaction is open, SCLK toggles on every system clock, so it runs at half the clock rate. SCLK is low whenever chip select is high.
- R4: MOSI changes only on falling SCLK edges and is stable across every rising SCLK edge.
- R5: MISO is sampled while SCLK is high, after each rising edge. Data bits are assembled MSB first.
- R6: Consecutive bytes come from consecutive flash addresses, and their valid strobes are exactly 16 clocks apart.
- R7: The valid strobe is high for exactly one clock per byte.
- R8: The first byte's valid strobe rises 80 clocks after the clock edge at which chip select fell.
- R9: Read-enable low at any point ends the transaction. On the next clock, chip select is high and SCLK is low. A partly received byte is discarded and gives no strobe.
- R10: A new assertion of read-enable after an abort sends a fresh opcode and address and starts from the new address.
- R11: Any 24-bit address is a valid start point, including the top of the address space. Reading past 0xFFFFFF continues at 0x000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read enable; rising opens a stream, low closes it |
| start_addr | input | 24 | Flash address of the first byte |
| rd_data | output | 8 | Last completed byte |
| rd_valid | output | 1 | One-clock strobe marking a new byte on rd_data |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sclk | output | 1 | Flash serial clock, idles low |
| flash_mosi | output | 1 | Serial data to flash |
| flash_miso | input | 1 | Serial data from flash |

## Verification
The bench uses a behavioural flash model. The model decodes the captured header and drives bytes from a computed address pattern.

It probes the following corner cases:

- **Header-to-data boundary.** The bench measures the exact latency of the first strobe. A controller that counted one header bit too many or too few would misalign every byte and miss the latency.
- **Mid-byte abort.** Read-enable drops in the middle of a byte. A design that kept its partial shift would emit a stray strobe, or carry stale bits into the next stream.
- **Abort during the header, followed by a restart.** This catches a design that resumes the old address instead of sending a fresh header.
- **Start near 0xFFFFFF.** The bench checks that the stream wraps to 0x000000 and keeps the 16-clock spacing.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HEADER = 2'd1,
        ST_STREAM = 2'd2
    } fsr_state_e;
endpackage

// File: rtl/fsr_tx_shift.sv
// Parallel-load, MSB-first output shifter for the command/address header.
module fsr_tx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] load_val,
    output logic         msb_o
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_val;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign msb_o = sh_q[W-1];

    // R2: a shift never coincides with a load
    p_no_load_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/fsr_rx_shift.sv
// MSB-first input shifter; flags the sample that completes a byte.
module fsr_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         din,
    output logic [W-1:0] byte_o,
    output logic         full_o
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    assign byte_o = {sh_q[W-2:0], din};
    assign full_o = sample && (cnt_q == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (sample) begin
            sh_q  <= byte_o;
            cnt_q <= full_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R9: after a clear the bit count restarts from zero
    p_clear_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/flash_stream_reader.sv
module flash_stream_reader
    import fsr_pkg::*;
#(
    parameter int                ADDR_W  = 24,
    parameter int                DATA_W  = 8,
    parameter int                CMD_W   = 8,
    parameter logic [CMD_W-1:0]  READ_OP = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              flash_cs_n,
    output logic              flash_sclk,
    output logic              flash_mosi,
    input  logic              flash_miso
);
    localparam int HDR_BITS = CMD_W + ADDR_W;
    localparam int HW       = $clog2(HDR_BITS);

    fsr_state_e        state_q, state_d;
    logic [HW-1:0]     bit_q;
    logic              sclk_q, cs_n_q, valid_q;
    logic [DATA_W-1:0] data_q;

    logic              tx_load, tx_shift, tx_msb;
    logic              rx_clear, rx_sample, rx_full;
    logic [DATA_W-1:0] rx_byte;
    logic              hdr_last;

    assign hdr_last  = sclk_q && (bit_q == HW'(HDR_BITS - 1));
    assign tx_load   = (state_q == ST_IDLE) && rd_en;
    assign tx_shift  = (state_q == ST_HEADER) && rd_en && sclk_q;
    assign rx_clear  = (state_q != ST_STREAM) || !rd_en;
    assign rx_sample = (state_q == ST_STREAM) && rd_en && sclk_q;

    fsr_tx_shift #(.W(HDR_BITS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .shift    (tx_shift),
        .load_val ({READ_OP, start_addr}),
        .msb_o    (tx_msb)
    );

    fsr_rx_shift #(.W(DATA_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (rx_clear),
        .sample (rx_sample),
        .din    (flash_miso),
        .byte_o (rx_byte),
        .full_o (rx_full)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (rd_en) state_d = ST_HEADER;
            ST_HEADER: begin
                if (!rd_en)        state_d = ST_IDLE;
                else if (hdr_last) state_d = ST_STREAM;
            end
            ST_STREAM: if (!rd_en) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            valid_q <= 1'b0;
            data_q  <= '0;
            bit_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    sclk_q <= 1'b0;
                    cs_n_q <= !rd_en;
                    bit_q  <= '0;
                end
                ST_HEADER: begin
                    if (!rd_en) begin
                        sclk_q <= 1'b0;
                        cs_n_q <= 1'b1;
                    end else begin
                        sclk_q <= !sclk_q;
                        if (sclk_q) bit_q <= bit_q + 1'b1;
                    end
                end
                ST_STREAM: begin
                    if (!rd_en) begin
                        sclk_q <= 1'b0;
                        cs_n_q <= 1'b1;
                    end else begin
                        sclk_q <= !sclk_q;
                        if (rx_full) begin
                            data_q  <= rx_byte;
                            valid_q <= 1'b1;
                        end
                    end
                end
                default: begin
                    sclk_q <= 1'b0;
                    cs_n_q <= 1'b1;
                end
            endcase
        end
    end

    assign rd_data    = data_q;
    assign rd_valid   = valid_q;
    assign flash_cs_n = cs_n_q;
    assign flash_sclk = sclk_q;
    assign flash_mosi = tx_msb;

    // R3: clock parked low whenever the flash is deselected
    p_sclk_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cs_n |-> !flash_sclk);

    // R3: clock toggles every cycle while a transaction continues
    p_sclk_toggles_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && rd_en) |=> (flash_sclk != $past(flash_sclk)));

    // R4: MOSI steady across each rising SCLK edge
    p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_cs_n && $rose(flash_sclk)) |-> $stable(flash_mosi));

    // R7: strobe lasts a single clock
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R9: enable low closes the bus and suppresses any strobe
    p_abort_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (flash_cs_n && !flash_sclk && !rd_valid));
endmodule

// File: tb/flash_stream_reader_test.sv
`timescale 1ns/1ps
module flash_stream_reader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [23:0] start_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        flash_cs_n, flash_sclk, flash_mosi;
    logic        flash_miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    flash_stream_reader uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .start_addr(start_addr),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .flash_cs_n(flash_cs_n), .flash_sclk(flash_sclk),
        .flash_mosi(flash_mosi), .flash_miso(flash_miso)
    );

    function automatic logic [7:0] mem(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[18:16], a[23:19]} ^ 8'h5A;
    endfunction

    // behavioural flash
    int          hcnt = 0;
    int          obit = 0;
    logic [31:0] hdr  = '0;
    logic [23:0] cur  = '0;
    logic [7:0]  obyte = '0;

    always @(posedge flash_cs_n) begin
        hcnt = 0;
        obit = 0;
    end
    always @(posedge flash_sclk) begin
        if (!flash_cs_n && hcnt < 32) begin
            hdr  = {hdr[30:0], flash_mosi};
            hcnt = hcnt + 1;
            if (hcnt == 32) cur = hdr[23:0];
        end
    end
    always @(negedge flash_sclk) begin
        if (!flash_cs_n && hcnt == 32) begin
            if (obit == 0) begin
                obyte = mem(cur);
                cur   = cur + 24'd1;
            end
            flash_miso = obyte[7 - obit];
            obit = (obit + 1) % 8;
        end
    end

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    // Start a read and collect n bytes; check data, latency, spacing, header.
    task automatic run_read(input logic [23:0] a, input int n, input string tag);
        int cyc = 0;
        int last = 0;
        int got = 0;
        @(negedge clk);
        start_addr = a;
        rd_en = 1'b1;
        while (got < n && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (rd_valid) begin
                if (got == 0) begin
                    check(cyc == 81, {tag, " R8 latency"}, cyc, 81);
                    check(hdr == {8'h03, a}, {tag, " R2 header"}, hdr, {8'h03, a});
                end else begin
                    check(cyc - last == 16, {tag, " R6 spacing"}, cyc - last, 16);
                end
                check(rd_data == mem(a + 24'(got)), {tag, " R5 R6 R11 data"},
                      rd_data, mem(a + 24'(got)));
                last = cyc;
                got++;
            end
        end
        check(got == n, {tag, " R6 byte count"}, got, n);
        rd_en = 1'b0;
        @(negedge clk);
        check(flash_cs_n && !flash_sclk, {tag, " R9 close"}, {flash_cs_n, flash_sclk}, 2'b10);
    endtask

    localparam logic [31:0] VEC [4] = '{
        {24'h000000, 8'd3},
        {24'h123456, 8'd5},
        {24'hA5F00F, 8'd2},
        {24'h7FFFFF, 8'd4}
    };

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(flash_cs_n && !flash_sclk && !rd_valid && rd_data == 8'h00, "R1 in reset",
              {flash_cs_n, flash_sclk, rd_valid, rd_data}, 11'h400);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(flash_cs_n && !flash_sclk && !rd_valid, "R1 idle after reset",
              {flash_cs_n, flash_sclk, rd_valid}, 3'b100);

        for (int i = 0; i < 4; i++) begin
            run_read(VEC[i][31:8], int'(VEC[i][7:0]), "vec");
            repeat (3) @(negedge clk);
        end

        // R2 R3: chip select falls on next edge, sclk toggles each cycle
        @(negedge clk);
        start_addr = 24'h00ABCD;
        rd_en = 1'b1;
        @(negedge clk);
        check(!flash_cs_n && !flash_sclk, "R2 select falls", {flash_cs_n, flash_sclk}, 2'b00);
        @(negedge clk);
        check(flash_sclk, "R3 sclk high", flash_sclk, 1);
        @(negedge clk);
        check(!flash_sclk, "R3 sclk low", flash_sclk, 0);

        // R9 R10: abort inside header, no strobe, then restart
        begin
            int seen = 0;
            repeat (18) @(negedge clk);
            rd_en = 1'b0;
            for (int k = 0; k < 120; k++) begin
                @(negedge clk);
                if (rd_valid) seen++;
            end
            check(seen == 0, "R9 header abort no strobe", seen, 0);
            check(flash_cs_n, "R9 header abort deselect", flash_cs_n, 1);
        end
        run_read(24'h345678, 2, "R10 restart");

        // R9: abort mid-byte, partial byte discarded
        begin
            int seen = 0;
            @(negedge clk);
            start_addr = 24'h0F0F0F;
            rd_en = 1'b1;
            while (!rd_valid) @(negedge clk);
            check(rd_data == mem(24'h0F0F0F), "R9 first byte", rd_data, mem(24'h0F0F0F));
            repeat (7) @(negedge clk);
            rd_en = 1'b0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (rd_valid) seen++;
            end
            check(seen == 0, "R9 mid-byte abort no strobe", seen, 0);
            check(flash_cs_n && !flash_sclk, "R9 mid-byte abort pins",
                  {flash_cs_n, flash_sclk}, 2'b10);
        end
        run_read(24'h0F0F20, 3, "R10 fresh header");

        // R11: wrap past top of address space
        run_read(24'hFFFFFE, 4, "R11 wrap");

        // R1: reset mid-stream
        @(negedge clk);
        start_addr = 24'h000100;
        rd_en = 1'b1;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(flash_cs_n && !flash_sclk && !rd_valid, "R1 reset mid-stream",
              {flash_cs_n, flash_sclk, rd_valid}, 3'b100);
        rd_en = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule